// File: doc/BRIEF.md
# Divisor-Aware System Control Register Bank

This block is a bank of 32-bit system control words behind a simple APB-style slave port. An access happens in any cycle where select and enable are both high. The byte address is turned into a word index by dropping its two low bits. Reads return data one cycle after the access, with no wait states. Writes always carry a full word; there are no byte strobes.

Two peripheral-bus clock divisors are fixed as build parameters. At reset, the block encodes both divisors and places the codes in a fabric clock control word. It also presets two PLL status words. The PLL status word and three memory-remap words refuse every write. When the refused write to a remap word carries data that differs from the stored content, a one-cycle "unsupported" flag is raised. An index beyond the bank depth reads as zero, cannot be written, and raises a one-cycle bad-address flag. The block performs no real PLL control, clock generation or address remapping.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two, so the two low address bits have no effect. A write to a plain in-range word stores the full data word. A read of an in-range word returns the stored word on the read data output in the cycle after the access. In every other cycle the read data output is zero.
- R2: After reset, the PLL low-status word reads 0x021A2358 and the PLL status word reads 0x3. Every word that has no preset reads zero.
- R3: After reset, the fabric clock control word holds the code of divisor 0 at bits 7:5 and the code of divisor 1 at bits 4:2. All of its other bits are zero. With the default divisors of 2 and 2, it reads 0x24.
- R4: A divisor's code is its log2 when the divisor is below 8, and its log2 plus one otherwise, so 1, 2, 4, 8, 16 and 32 map to 0, 1, 2, 4, 5 and 6. A divisor that is not a power of two, or that exceeds 32, stops elaboration.
- R5: A write to the PLL status word is discarded, and the word keeps its value.
- R6: Writes to the SRAM-remap, DDR-remap and NVM-remap-base words are discarded, and those words keep reading zero.
- R7: The unsupported flag goes high for exactly the cycle after a write to a remap word whose data differs from the stored content. Otherwise it stays low.
- R8: A read of an index at or beyond the depth returns zero. The bad-address flag goes high for the cycle after that access.
- R9: A write to an index at or beyond the depth changes no stored word. The bad-address flag goes high for the cycle after that write, and the unsupported flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selIn | input | 1 | Slave select |
| enableIn | input | 1 | Access phase; with selIn, marks an access |
| writeIn | input | 1 | 1 = write, 0 = read |
| addrIn | input | ADDR_W | Byte address |
| wdataIn | input | DATA_W | Write data |
| rdataOut | output | DATA_W | Read data, one cycle after the read |
| badAddrOut | output | 1 | One-cycle flag for an out-of-range access |
| unsupOut | output | 1 | One-cycle flag for a refused remap write with changed data |

## Verification
On a write to a remap word, two things happen in the same cycle: the write is discarded, and the incoming data is compared with the stored content. That comparison decides whether the unsupported flag fires. The bench provokes this by writing each remap word first with its current value (zero) and then with a differing value. It then reads the word back, which shows that the flag fired only for the differing data and that the content never moved. A reference model predicts the read data and both flags every cycle and compares them with the outputs. It is also checked that an out-of-range write never aliases onto an in-range word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [31:0] PLL_LOW_RST  = 32'h021A_2358;
  localparam logic [31:0] PLL_STAT_RST = 32'h0000_0003;
  localparam int          FACC_SHIFT0  = 5;
  localparam int          FACC_SHIFT1  = 2;

  typedef struct packed {
    logic store;    // plain in-range write
    logic load;     // in-range read
    logic remapWr;  // write aimed at a remap word
    logic badAcc;   // index beyond depth
  } ctlStrobe_t;

  function automatic bit divLegal(int d);
    return (d >= 1) && (d <= 32) && ((d & (d - 1)) == 0);
  endfunction

  // log2 for small divisors, one extra step from 8 upwards
  function automatic int divCode(int d);
    return (d < 8) ? $clog2(d) : $clog2(d) + 1;
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int IDX_W          = ADDR_W - 2,
  parameter int DEPTH          = 192,
  parameter int IDX_PLL_STAT   = 26,
  parameter int IDX_SRAM_REMAP = 0,
  parameter int IDX_DDR_REMAP  = 1,
  parameter int IDX_NVM_REMAP  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              enableIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  output ctlStrobe_t        strb,
  output logic [IDX_W-1:0]  idxOut,
  output logic              badAddrOut
);

  localparam logic [IDX_W-1:0] STAT_I = IDX_W'(IDX_PLL_STAT);
  localparam logic [IDX_W-1:0] SRAM_I = IDX_W'(IDX_SRAM_REMAP);
  localparam logic [IDX_W-1:0] DDR_I  = IDX_W'(IDX_DDR_REMAP);
  localparam logic [IDX_W-1:0] NVM_I  = IDX_W'(IDX_NVM_REMAP);

  logic [ADDR_W-1:0] wordAddr;
  logic access, inRange, isRemap, isLocked;

  assign wordAddr = addrIn >> 2;
  assign idxOut   = wordAddr[IDX_W-1:0];
  assign access   = selIn && enableIn;
  assign inRange  = int'(wordAddr) < DEPTH;
  assign isRemap  = (idxOut == SRAM_I) || (idxOut == DDR_I) || (idxOut == NVM_I);
  assign isLocked = (idxOut == STAT_I);

  always_comb begin
    strb.store   = access && writeIn && inRange && !isRemap && !isLocked;
    strb.load    = access && !writeIn && inRange;
    strb.remapWr = access && writeIn && inRange && isRemap;
    strb.badAcc  = access && !inRange;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) badAddrOut <= 1'b0;
    else       badAddrOut <= strb.badAcc;
  end

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 192,
  parameter int IDX_W        = 8,
  parameter int IDX_PLL_LOW  = 25,
  parameter int IDX_PLL_STAT = 26,
  parameter int IDX_FACC     = 20,
  parameter int FACC_RST     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [IDX_W-1:0]  idxIn,
  input  logic [DATA_W-1:0] wdataIn,
  output logic [DATA_W-1:0] rdataOut,
  output logic              unsupOut
);

  logic [DATA_W-1:0] regMem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [DATA_W-1:0] RST =
      (w == IDX_PLL_LOW)  ? DATA_W'(PLL_LOW_RST)  :
      (w == IDX_PLL_STAT) ? DATA_W'(PLL_STAT_RST) :
      (w == IDX_FACC)     ? DATA_W'(FACC_RST)     : '0;
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   word <= RST;
      else if (strb.store && idxIn == IDX_W'(w))   word <= wdataIn;
    end
    assign regMem[w] = word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataOut <= '0;
      unsupOut <= 1'b0;
    end else begin
      rdataOut <= strb.load ? regMem[idxIn] : '0;
      unsupOut <= strb.remapWr && (wdataIn != regMem[idxIn]);
    end
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 10,
  parameter int DEPTH          = 192,
  parameter int DIV0           = 2,
  parameter int DIV1           = 2,
  parameter int IDX_PLL_LOW    = 25,
  parameter int IDX_PLL_STAT   = 26,
  parameter int IDX_FACC       = 20,
  parameter int IDX_SRAM_REMAP = 0,
  parameter int IDX_DDR_REMAP  = 1,
  parameter int IDX_NVM_REMAP  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic              enableIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  output logic [DATA_W-1:0] rdataOut,
  output logic              badAddrOut,
  output logic              unsupOut
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int FACC_RST = (divCode(DIV0) << FACC_SHIFT0) | (divCode(DIV1) << FACC_SHIFT1);

  if (!divLegal(DIV0) || !divLegal(DIV1)) begin : g_badDiv
    $error("divisors must be powers of two no larger than 32");
  end
  if (DATA_W < 32 || (1 << IDX_W) < DEPTH) begin : g_badGeom
    $error("data width below 32 or address too narrow for depth");
  end

  ctlStrobe_t       strb;
  logic [IDX_W-1:0] idx;

  sysctl_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH),
    .IDX_PLL_STAT(IDX_PLL_STAT), .IDX_SRAM_REMAP(IDX_SRAM_REMAP),
    .IDX_DDR_REMAP(IDX_DDR_REMAP), .IDX_NVM_REMAP(IDX_NVM_REMAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn),
    .writeIn(writeIn), .addrIn(addrIn), .strb(strb), .idxOut(idx),
    .badAddrOut(badAddrOut)
  );

  sysctl_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
    .IDX_PLL_LOW(IDX_PLL_LOW), .IDX_PLL_STAT(IDX_PLL_STAT),
    .IDX_FACC(IDX_FACC), .FACC_RST(FACC_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idxIn(idx), .wdataIn(wdataIn),
    .rdataOut(rdataOut), .unsupOut(unsupOut)
  );

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              selIn,
  input logic              enableIn,
  input logic              writeIn,
  input logic [DATA_W-1:0] rdataOut,
  input logic              badAddrOut,
  input logic              unsupOut
);

  a_r1_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rstN)
    !$past(selIn && enableIn && !writeIn) |-> rdataOut == '0);

  a_r8_bad_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    badAddrOut |-> rdataOut == '0);

  a_r8_bad_after_access: assert property (@(posedge clk) disable iff (!rstN)
    badAddrOut |-> $past(selIn && enableIn));

  a_r7_unsup_after_write: assert property (@(posedge clk) disable iff (!rstN)
    unsupOut |-> $past(selIn && enableIn && writeIn));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(badAddrOut && unsupOut));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn),
  .writeIn(writeIn), .rdataOut(rdataOut), .badAddrOut(badAddrOut),
  .unsupOut(unsupOut)
);

// File: tb/sysctl_regbank_tb_top.sv
module sysctl_regbank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, AW = 10, DEP = 192;
  localparam int I_LOW = 25, I_STAT = 26, I_FACC = 20;
  localparam int I_SRAM = 0, I_DDR = 1, I_NVM = 2;

  logic clk = 0, rstN = 0;
  logic selIn = 0, enableIn = 0, writeIn = 0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] wdataIn = '0;
  logic [DW-1:0] rdata, rdata2;
  logic bad, unsup, bad2, unsup2;

  int tests = 0, fails = 0;
  string curReq = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regbank #(.DEPTH(DEP), .DIV0(2), .DIV1(2)) dut_i (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn), .writeIn(writeIn),
    .addrIn(addrIn), .wdataIn(wdataIn), .rdataOut(rdata), .badAddrOut(bad), .unsupOut(unsup));

  sysctl_regbank #(.DEPTH(DEP), .DIV0(8), .DIV1(32)) dut2_i (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn), .writeIn(writeIn),
    .addrIn(addrIn), .wdataIn(wdataIn), .rdataOut(rdata2), .badAddrOut(bad2), .unsupOut(unsup2));

  function automatic int code(int d);
    int tz = 0;
    int v = d;
    while (v > 1) begin v = v / 2; tz++; end
    return (d >= 8) ? tz + 1 : tz;
  endfunction

  // reference model
  logic [31:0] mdl [int];
  logic [31:0] expRd = 0;
  logic expBad = 0, expUnsup = 0;

  function automatic logic [31:0] peek(int i);
    return mdl.exists(i) ? mdl[i] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mdl.delete();
      mdl[I_LOW]  = 32'h021A2358;
      mdl[I_STAT] = 32'h3;
      mdl[I_FACC] = (code(2) << 5) | (code(2) << 2);
      expRd = 0; expBad = 0; expUnsup = 0;
    end else begin
      int i;
      i = int'(addrIn) / 4;
      expRd = 0; expBad = 0; expUnsup = 0;
      if (selIn && enableIn) begin
        if (i >= DEP) expBad = 1;
        else if (writeIn) begin
          if (i == I_SRAM || i == I_DDR || i == I_NVM) expUnsup = (wdataIn != peek(i));
          else if (i != I_STAT) mdl[i] = wdataIn;
        end else expRd = peek(i);
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(curReq, "rdata", rdata, expRd);
    check(curReq, "badAddr", 32'(bad), 32'(expBad));
    check(curReq, "unsup", 32'(unsup), 32'(expUnsup));
  end

  task automatic acc(bit wr, int byteAddr, logic [31:0] d);
    @(negedge clk);
    selIn = 1; enableIn = 1; writeIn = wr; addrIn = AW'(byteAddr); wdataIn = d;
    @(negedge clk);
    selIn = 0; enableIn = 0; writeIn = 0; wdataIn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R2";
    acc(0, I_LOW*4, 0); acc(0, I_STAT*4, 0); acc(0, 5*4, 0); acc(0, 191*4, 0);
    curReq = "R3";
    acc(0, I_FACC*4, 0);
    // second instance shares the bus: divisors 8 and 32 give codes 4 and 6
    @(negedge clk);
    selIn = 1; enableIn = 1; addrIn = AW'(I_FACC*4);
    @(negedge clk);
    check("R4", "facc divisors 8/32", rdata2, (code(8) << 5) | (code(32) << 2));
    check("R4", "code table", {code(1),code(2),code(4),code(8),code(16),code(32)} == {0,1,2,4,5,6} ? 1 : 0, 1);
    selIn = 0; enableIn = 0;
    curReq = "R1";
    acc(1, 5*4, 32'hDEADBEEF); acc(0, 5*4, 0);
    acc(1, 191*4, 32'hA5A5_0F0F); acc(0, 191*4 + 2, 0);
    acc(1, 7*4 + 3, 32'h1234_5678); acc(0, 7*4, 0);
    acc(1, I_FACC*4, 32'hFFFF_FFFF); acc(0, I_FACC*4, 0);
    for (int k = 30; k < 40; k++) acc(1, k*4, 32'(k * 32'h0101_0101));
    for (int k = 30; k < 40; k++) acc(0, k*4, 0);
    curReq = "R5";
    acc(1, I_STAT*4, 32'h0); acc(0, I_STAT*4, 0);
    acc(1, I_STAT*4, 32'hFFFF_FFFF); acc(0, I_STAT*4, 0);
    curReq = "R7";
    acc(1, I_SRAM*4, 32'h0); acc(1, I_SRAM*4, 32'h1234);
    acc(1, I_DDR*4, 32'h0);  acc(1, I_DDR*4, 32'h8000_0000);
    acc(1, I_NVM*4, 32'h0);  acc(1, I_NVM*4, 32'h1);
    curReq = "R6";
    acc(0, I_SRAM*4, 0); acc(0, I_DDR*4, 0); acc(0, I_NVM*4, 0);
    curReq = "R8";
    acc(0, 192*4, 0); acc(0, 255*4 + 3, 0);
    curReq = "R9";
    acc(1, (192 + 5)*4, 32'hBAD0_BAD0); acc(1, 250*4, 32'h1111_2222);
    acc(0, 5*4, 0); acc(0, (192 + 5)*4, 0);
    curReq = "R2";
    rstN = 0; repeat (2) @(negedge clk); rstN = 1;
    acc(0, 5*4, 0); acc(0, I_STAT*4, 0); acc(0, I_LOW*4, 0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule